// File: doc/BRIEF.md
# Reservation Monitor for Atomic Load/Store Pairs

This block keeps the single reservation that a core uses for atomic read-modify-write sequences. Test-and-set, compare-and-swap, exchange and fetch-and-add are all built from two operations. A reserving load opens the reservation. A conditional store may write only if nothing has disturbed that reservation in between. The load side records which naturally aligned 32-byte granule the effective address falls in and marks the reservation live. The store side asks whether the reservation is still live for its own granule, and the monitor answers with a success flag. Data movement is not part of this block: the pipeline presents one operation per cycle and uses the answer to commit or drop the store.

Write traffic from other agents is snooped on one or more ports. A snooped write into the reserved granule kills the reservation. Three conditions stop an operation from executing, and each raises an interrupt request: an address that is not word-aligned, a page marked write-through, or a locked data cache. The reservation is left as it was when any of these occurs.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset all four outputs are 0 and no reservation exists, so a first conditional store reports failure.
- R2: A fault-free reserving load followed by a fault-free conditional store to any word-aligned address in the same 32-byte granule gives `sc_done`=1 and `sc_success`=1. These are visible in the cycle after the store is presented.
- R3: Every fault-free conditional store clears the reservation, whatever its result. A second store to the same granule therefore fails.
- R4: A conditional store whose granule (address bits above bit 4) differs from the reserved one reports `sc_done`=1 and `sc_success`=0.
- R5: An operation with `op_addr[1:0]` not zero raises `irq_align`. It raises `irq_align` only, even when a data-storage condition is also present.
- R6: A word-aligned operation whose page attribute has `op_pattr[3]`=1 (write-through) and `op_pattr[2]`=0 (not cache-inhibited) raises `irq_dsi`.
- R7: A word-aligned operation while `dcache_locked`=1 raises `irq_dsi`.
- R8: A faulting operation leaves the reservation unchanged. A faulting conditional store gives `sc_done`=0.
- R9: A valid snooped write on any port whose address lies in the reserved granule clears the reservation, and a conditional store in that same cycle fails. A snooped write to another granule leaves the reservation alone.
- R10: A new fault-free reserving load replaces any earlier reservation with its own granule.
- R11: Operation codes: 2'b01 reserving load, 2'b10 conditional store. Codes 2'b00 and 2'b11 do nothing, and every output is a one-cycle pulse tied to its operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 2 | Operation code (see R11) |
| op_addr | input | ADDR_W | Effective address of the operation |
| op_pattr | input | 4 | Page attributes; bit 3 write-through, bit 2 cache-inhibited |
| dcache_locked | input | 1 | Data cache is locked |
| snoop_valid | input | NUM_SNOOP | Per-port snooped write strobe |
| snoop_addr | input | NUM_SNOOP*ADDR_W | Per-port snooped write address, port 0 in the low bits |
| sc_done | output | 1 | A conditional store was evaluated |
| sc_success | output | 1 | The conditional store may commit |
| irq_align | output | 1 | Alignment interrupt request |
| irq_dsi | output | 1 | Data storage interrupt request |

## Verification
Some properties are checked by the assertions on every cycle. The two interrupt requests never rise together, and success never appears without `sc_done`. Each internal event has a fixed effect on the reservation register in the following cycle: a load sets it, a store clears it, a snoop hit clears it. A faulting operation leaves the register untouched. Other behaviour shows up only in the bench's sequences, because it depends on history over several operations. These sequences cover replacement by a second load, success anywhere inside the granule, a snoop to a neighbouring granule having no effect, and a snoop that arrives together with the store.

// File: rtl/lrsc_pkg.sv
// Package: shared operation codes for the reservation monitor.
// Assumes one operation per cycle; codes outside the enum act as idle.
package lrsc_pkg;
    typedef enum logic [1:0] {
        OPK_IDLE  = 2'b00,
        OPK_LOAD  = 2'b01,
        OPK_STORE = 2'b10,
        OPK_RSVD  = 2'b11
    } op_kind_e;

    // Page attribute bit positions decoded by the fault checker.
    localparam int unsigned PATTR_WT_BIT = 3;
    localparam int unsigned PATTR_CI_BIT = 2;
endpackage

// File: rtl/lrsc_fault_check.sv
// Module: lrsc_fault_check
// Decides combinationally whether an atomic operation must trap instead of
// executing. Alignment is tested first and masks the data-storage causes.
// Assumes WORD_BYTES is a power of two.
module lrsc_fault_check #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        pattr,
    input  logic              cache_locked,
    output logic              flt_align,
    output logic              flt_dsi,
    output logic              flt_any
);
    import lrsc_pkg::*;

    localparam int unsigned ALIGN_W = $clog2(WORD_BYTES);

    logic                unused_hi;
    logic                raw_dsi;

    assign unused_hi = ^{addr[ADDR_W-1:ALIGN_W], pattr[1:0]};

    // Raw data-storage cause: write-through page or locked cache.
    always_comb begin
        raw_dsi = cache_locked ||
                  (pattr[PATTR_WT_BIT] && !pattr[PATTR_CI_BIT]);
    end

    // Prioritise alignment over the data-storage causes.
    always_comb begin
        flt_align = (addr[ALIGN_W-1:0] != '0);
        flt_dsi   = !flt_align && raw_dsi;
        flt_any   = flt_align || raw_dsi;
    end

    // Checks that the prioritised causes never both appear.
    always_comb begin
        a_fault_excl_r5: assert (!(flt_align && flt_dsi))
            else $error("fault causes overlap");
    end
endmodule

// File: rtl/lrsc_snoop_match.sv
// Module: lrsc_snoop_match
// Compares every snoop port against the reserved granule tag and ORs the
// results. Assumes snoop addresses are packed port 0 lowest.
module lrsc_snoop_match #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned OFS_W     = 5,
    parameter int unsigned NUM_SNOOP = 2
) (
    input  logic [NUM_SNOOP-1:0]        snoop_valid,
    input  logic [NUM_SNOOP*ADDR_W-1:0] snoop_addr,
    input  logic                        rsv_valid,
    input  logic [ADDR_W-OFS_W-1:0]     rsv_tag,
    output logic                        snoop_hit
);
    localparam int unsigned TAG_W = ADDR_W - OFS_W;

    logic [NUM_SNOOP-1:0] port_hit;

    // One comparator per snoop port.
    for (genvar g = 0; g < NUM_SNOOP; g++) begin : g_port
        logic [ADDR_W-1:0] one_addr;
        logic [TAG_W-1:0]  one_tag;
        logic              unused_ofs;
        assign one_addr   = snoop_addr[g*ADDR_W +: ADDR_W];
        assign one_tag    = one_addr[ADDR_W-1:OFS_W];
        assign unused_ofs = ^one_addr[OFS_W-1:0];
        assign port_hit[g] = snoop_valid[g] && (one_tag == rsv_tag);
    end

    // Any live port hit kills the reservation.
    always_comb begin
        snoop_hit = rsv_valid && (port_hit != '0);
    end
endmodule

// File: rtl/lrsc_resv_reg.sv
// Module: lrsc_resv_reg
// Holds the reservation flag and granule tag. Priority: a new reserving load
// wins, then a conditional-store clear, then a snoop clear.
module lrsc_resv_reg #(
    parameter int unsigned TAG_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_set,
    input  logic [TAG_W-1:0] load_tag,
    input  logic             store_clr,
    input  logic             snoop_clr,
    output logic             rsv_valid,
    output logic [TAG_W-1:0] rsv_tag
);
    // Update the single reservation entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsv_valid <= 1'b0;
            rsv_tag   <= '0;
        end else if (load_set) begin
            rsv_valid <= 1'b1;
            rsv_tag   <= load_tag;
        end else if (store_clr || snoop_clr) begin
            rsv_valid <= 1'b0;
        end
    end

    p_load_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_set |=> (rsv_valid && rsv_tag == $past(load_tag)))
        else $error("reserving load did not install tag");

    p_store_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (store_clr && !load_set) |=> !rsv_valid)
        else $error("conditional store left reservation live");

    p_snoop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_clr && !load_set) |=> !rsv_valid)
        else $error("snoop hit left reservation live");
endmodule

// File: rtl/lrsc_monitor.sv
// Module: lrsc_monitor (top)
// Single-entry reservation monitor for reserving-load / conditional-store
// pairs. Results and interrupt requests are registered and appear one cycle
// after the operation. Assumes at most one operation per cycle.
module lrsc_monitor #(
    parameter int unsigned ADDR_W        = 32,
    parameter int unsigned GRANULE_BYTES = 32,
    parameter int unsigned WORD_BYTES    = 4,
    parameter int unsigned NUM_SNOOP     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        op_valid,
    input  logic [1:0]                  op_kind,
    input  logic [ADDR_W-1:0]           op_addr,
    input  logic [3:0]                  op_pattr,
    input  logic                        dcache_locked,
    input  logic [NUM_SNOOP-1:0]        snoop_valid,
    input  logic [NUM_SNOOP*ADDR_W-1:0] snoop_addr,
    output logic                        sc_done,
    output logic                        sc_success,
    output logic                        irq_align,
    output logic                        irq_dsi
);
    import lrsc_pkg::*;

    localparam int unsigned OFS_W = $clog2(GRANULE_BYTES);
    localparam int unsigned TAG_W = ADDR_W - OFS_W;

    logic             is_load, is_store;
    logic             flt_align, flt_dsi, flt_any;
    logic             snoop_hit;
    logic             rsv_valid;
    logic [TAG_W-1:0] rsv_tag;
    logic [TAG_W-1:0] op_tag;
    logic             load_go, store_go, tag_ok;

    assign op_tag = op_addr[ADDR_W-1:OFS_W];

    // Decode the presented operation.
    always_comb begin
        is_load  = op_valid && (op_kind == OPK_LOAD);
        is_store = op_valid && (op_kind == OPK_STORE);
    end

    lrsc_fault_check #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_fault (
        .addr         (op_addr),
        .pattr        (op_pattr),
        .cache_locked (dcache_locked),
        .flt_align    (flt_align),
        .flt_dsi      (flt_dsi),
        .flt_any      (flt_any)
    );

    lrsc_snoop_match #(
        .ADDR_W    (ADDR_W),
        .OFS_W     (OFS_W),
        .NUM_SNOOP (NUM_SNOOP)
    ) u_snoop (
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .rsv_valid   (rsv_valid),
        .rsv_tag     (rsv_tag),
        .snoop_hit   (snoop_hit)
    );

    // Qualify operations that execute, and test the store's tag.
    always_comb begin
        load_go  = is_load  && !flt_any;
        store_go = is_store && !flt_any;
        tag_ok   = rsv_valid && (rsv_tag == op_tag) && !snoop_hit;
    end

    lrsc_resv_reg #(
        .TAG_W (TAG_W)
    ) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_set  (load_go),
        .load_tag  (op_tag),
        .store_clr (store_go),
        .snoop_clr (snoop_hit),
        .rsv_valid (rsv_valid),
        .rsv_tag   (rsv_tag)
    );

    // Register the per-operation result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_done    <= 1'b0;
            sc_success <= 1'b0;
            irq_align  <= 1'b0;
            irq_dsi    <= 1'b0;
        end else begin
            sc_done    <= store_go;
            sc_success <= store_go && tag_ok;
            irq_align  <= (is_load || is_store) && flt_align;
            irq_dsi    <= (is_load || is_store) && flt_dsi;
        end
    end

    p_irq_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_align && irq_dsi))
        else $error("both interrupt requests raised");

    p_success_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sc_success |-> sc_done)
        else $error("success without done");

    p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((is_load || is_store) && flt_any && !snoop_hit) |=>
            ($stable(rsv_valid) && $stable(rsv_tag)))
        else $error("faulting op changed reservation");

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_load && !is_store) |=> !(sc_done || irq_align || irq_dsi))
        else $error("output pulse without an operation");
endmodule

// File: tb/tb_lrsc_monitor.sv
// Directed bench for lrsc_monitor: one task per scenario.
module tb_lrsc_monitor;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned NSN    = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic [1:0]        op_kind = 2'b00;
    logic [ADDR_W-1:0] op_addr = '0;
    logic [3:0]        op_pattr = 4'h0;
    logic              dcache_locked = 1'b0;
    logic [NSN-1:0]    snoop_valid = '0;
    logic [NSN*ADDR_W-1:0] snoop_addr = '0;
    logic sc_done, sc_success, irq_align, irq_dsi;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam logic [1:0] K_LD = 2'b01, K_SC = 2'b10;
    localparam logic [31:0] A = 32'h0000_1000, B = 32'h0000_1020;

    always #4 clk = ~clk;

    lrsc_monitor dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_addr(op_addr), .op_pattr(op_pattr), .dcache_locked(dcache_locked),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .sc_done(sc_done), .sc_success(sc_success),
        .irq_align(irq_align), .irq_dsi(irq_dsi)
    );

    // Result vector {done, success, align, dsi} captured after an op.
    logic [3:0] res;

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Present one operation (optionally with a snoop) and capture the result.
    task automatic op(input logic [1:0] k, input logic [31:0] a,
                      input logic [3:0] pa, input logic lk,
                      input logic [NSN-1:0] sv, input logic [31:0] sa);
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; op_addr = a; op_pattr = pa;
        dcache_locked = lk; snoop_valid = sv;
        snoop_addr = {NSN{sa}};
        @(negedge clk);
        op_valid = 1'b0; op_kind = 2'b00; dcache_locked = 1'b0;
        snoop_valid = '0;
        res = {sc_done, sc_success, irq_align, irq_dsi};
    endtask

    task automatic plain(input logic [1:0] k, input logic [31:0] a);
        op(k, a, 4'h0, 1'b0, '0, '0);
    endtask

    task automatic t_reset;
        chk("R1 reset outputs", {sc_done, sc_success, irq_align, irq_dsi}, 4'b0000);
        plain(K_SC, A); chk("R1 no reservation after reset", res, 4'b1000);
    endtask

    task automatic t_pair;
        plain(K_LD, A);        chk("R2 load has no pulse", res, 4'b0000);
        plain(K_SC, A + 32'h1C); chk("R2 store same granule", res, 4'b1100);
        plain(K_SC, A);        chk("R3 second store fails", res, 4'b1000);
    endtask

    task automatic t_other_granule;
        plain(K_LD, A);
        plain(K_SC, B); chk("R4 store other granule", res, 4'b1000);
        plain(K_SC, A); chk("R3 failed store still cleared", res, 4'b1000);
    endtask

    task automatic t_faults;
        plain(K_LD, A);
        op(K_LD, B + 2, 4'h0, 1'b0, '0, '0); chk("R5 misaligned load", res, 4'b0010);
        op(K_SC, A + 1, 4'h8, 1'b1, '0, '0); chk("R5 align over dsi", res, 4'b0010);
        op(K_LD, B, 4'h8, 1'b0, '0, '0);     chk("R6 write-through load", res, 4'b0001);
        op(K_SC, A, 4'hC, 1'b0, '0, '0);     chk("R6 wt+ci not a fault (R8 clears)", res, 4'b1100);
        plain(K_LD, A);
        op(K_SC, A, 4'h0, 1'b1, '0, '0);     chk("R7 locked cache store", res, 4'b0001);
        plain(K_SC, A); chk("R8 reservation kept over faults", res, 4'b1100);
    endtask

    task automatic t_snoop;
        plain(K_LD, A);
        op(2'b00, 32'h0, 4'h0, 1'b0, 2'b10, B); chk("R9 idle with miss snoop", res, 4'b0000);
        plain(K_SC, A); chk("R9 miss snoop keeps reservation", res, 4'b1100);
        plain(K_LD, A);
        op(2'b00, 32'h0, 4'h0, 1'b0, 2'b10, A + 32'h8);
        plain(K_SC, A); chk("R9 hit snoop on port 1 clears", res, 4'b1000);
        plain(K_LD, A);
        op(K_SC, A, 4'h0, 1'b0, 2'b01, A + 32'h4); chk("R9 snoop with store", res, 4'b1000);
    endtask

    task automatic t_replace;
        plain(K_LD, A);
        plain(K_LD, B);
        plain(K_SC, A); chk("R10 old granule dropped", res, 4'b1000);
        plain(K_LD, A);
        plain(K_LD, B);
        plain(K_SC, B); chk("R10 new granule held", res, 4'b1100);
    endtask

    task automatic t_codes;
        plain(K_LD, A);
        op(2'b11, A + 1, 4'h8, 1'b1, '0, '0); chk("R11 code 11 does nothing", res, 4'b0000);
        @(negedge clk);
        chk("R11 pulse lasts one cycle", {sc_done, sc_success, irq_align, irq_dsi}, 4'b0000);
        plain(K_SC, A); chk("R11 code 11 left reservation", res, 4'b1100);
        @(negedge clk);
        chk("R11 success pulse ends", {sc_done, sc_success, irq_align, irq_dsi}, 4'b0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_pair;
        t_other_granule;
        t_faults;
        t_snoop;
        t_replace;
        t_codes;
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule